// File: doc/BRIEF.md
# RV32I Execute Stage

This block is the purely combinational execute stage of a single-cycle 32-bit integer core. It takes the fetched instruction word, the address of that instruction, the two register-file read values, the already decoded immediate and two operand-source selects supplied by the decoder. From the instruction it works out which arithmetic or logic function to apply. It forms the two ALU operands from the selects and produces the ALU result. In the same pass it decides whether control transfers and where to.

The branch target is not computed by a separate adder. Control-transfer instructions run the ALU as an adder on the program counter (or rs1) and the immediate, and that sum doubles as the target handed to the fetch stage. Whether a conditional branch is taken is decided by an independent comparator that looks only at the two register values, so the ALU is free to form the target in the same cycle. The datapath width, the shifter structure and the comparator structure are parameters. The instruction word stays 32 bits.

Top module: `rvx_exec_unit`

## Requirements
- R1: With `op1_pc_sel_i` low the first ALU operand is `rs1_val_i`; with it high the first operand is `pc_i`.
- R2: With `op2_imm_sel_i` low the second ALU operand is `rs2_val_i`; with it high the second operand is `imm_i`.
- R3: For register-register (opcode 0110011) and register-immediate (opcode 0010011) instructions, funct3 (bits 14:12) selects the function: 000 add, 100 xor, 110 or, 111 and. For the register-register opcode, funct3 000 with bit 30 set gives a subtraction (operand 1 minus operand 2).
- R4: funct3 001 shifts left and funct3 101 shifts right, logically when bit 30 is clear and arithmetically when it is set. The shift amount is the low 5 bits of operand 2 only.
- R5: funct3 010 yields 1 when operand 1 is below operand 2 as two's-complement numbers, and 0 otherwise. funct3 011 does the same comparison on unsigned numbers.
- R6: Branch (1100011), jal (1101111), jalr (1100111), load (0000011), store (0100011), lui (0110111) and auipc (0010111) make the ALU add its operands. For branches and jal the jump target equals that sum.
- R7: For a conditional branch with funct3 000 (equal) the jump flag is 1 exactly when the two register values match; with funct3 001 (not equal) exactly when they differ. This holds whatever the operand selects pick.
- R8: For funct3 100 / 101 the jump flag is 1 when rs1 is below / not below rs2 as signed numbers. For funct3 110 / 111 the same comparisons are made on unsigned numbers.
- R9: jal always raises the jump flag, and the target is the instruction address plus the immediate.
- R10: jalr always raises the jump flag. The target is rs1 plus the immediate with bit 0 forced to 0, while the ALU result keeps the unmasked sum.
- R11: The jump flag is 0 for every opcode other than branch, jal and jalr, and for branch encodings with funct3 010 or 011.
- R12: An opcode outside the set listed in R3 and R6 gives an ALU result of 0 and a jump flag of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word being executed |
| pc_i | input | XLEN | Address of the instruction |
| rs1_val_i | input | XLEN | First register read value |
| rs2_val_i | input | XLEN | Second register read value |
| imm_i | input | XLEN | Sign-extended immediate from decode |
| op1_pc_sel_i | input | 1 | Operand 1 source: 0 rs1, 1 instruction address |
| op2_imm_sel_i | input | 1 | Operand 2 source: 0 rs2, 1 immediate |
| alu_result_o | output | XLEN | ALU result |
| jump_taken_o | output | 1 | Control transfer requested |
| jump_target_o | output | XLEN | Address to fetch from when the flag is set |

## Verification
For a conditional branch the ALU forms the target from the instruction address and immediate while the comparator decides on the register values, all in one evaluation. The bench provokes both together by sweeping every branch funct3 over register pairs that are equal, differ only in sign, or differ in magnitude, with both selects high and unrelated address and immediate values. Each vector is judged twice against arithmetic done in the bench: the flag against a signed or unsigned comparison of the register values, and the result and target against the address-plus-immediate sum. A comparator that wrongly read the ALU operands, or a target taken from the wrong operand, would then show up.

// File: rtl/rvx_exec_pkg.sv
package rvx_exec_pkg;

   typedef enum logic [3:0] {
      FN_NONE = 4'd0,
      FN_ADD  = 4'd1,
      FN_SUB  = 4'd2,
      FN_SLL  = 4'd3,
      FN_SLT  = 4'd4,
      FN_XOR  = 4'd5,
      FN_OR   = 4'd6,
      FN_AND  = 4'd7,
      FN_SRL  = 4'd8,
      FN_SRA  = 4'd9,
      FN_SLTU = 4'd10
   } alu_fn_e;

   localparam logic [6:0] OPC_REG    = 7'b0110011;
   localparam logic [6:0] OPC_IMM    = 7'b0010011;
   localparam logic [6:0] OPC_BRANCH = 7'b1100011;
   localparam logic [6:0] OPC_JAL    = 7'b1101111;
   localparam logic [6:0] OPC_JALR   = 7'b1100111;
   localparam logic [6:0] OPC_LOAD   = 7'b0000011;
   localparam logic [6:0] OPC_STORE  = 7'b0100011;
   localparam logic [6:0] OPC_LUI    = 7'b0110111;
   localparam logic [6:0] OPC_AUIPC  = 7'b0010111;

   localparam logic [2:0] CMP_EQ  = 3'b000;
   localparam logic [2:0] CMP_NE  = 3'b001;
   localparam logic [2:0] CMP_LT  = 3'b100;
   localparam logic [2:0] CMP_GE  = 3'b101;
   localparam logic [2:0] CMP_LTU = 3'b110;
   localparam logic [2:0] CMP_GEU = 3'b111;

   typedef struct packed {
      logic [6:0] opcode;
      logic [2:0] funct3;
      logic       alt;
   } inst_fields_t;

   function automatic inst_fields_t split_fields(input logic [31:0] w);
      inst_fields_t f;
      f.opcode = w[6:0];
      f.funct3 = w[14:12];
      f.alt    = w[30];
      return f;
   endfunction

endpackage

// File: rtl/rvx_exec_fn_decode.sv
module rvx_exec_fn_decode
   import rvx_exec_pkg::*;
(
   input  logic [31:0] instr_i,
   output alu_fn_e     fn_o,
   output logic [2:0]  funct3_o,
   output logic        is_branch_o,
   output logic        is_jump_o,
   output logic        is_jalr_o
);

   inst_fields_t fld;
   logic         unused_bits;

   assign fld         = split_fields(instr_i);
   assign unused_bits = ^{instr_i[31], instr_i[29:15], instr_i[11:7]};
   assign funct3_o    = fld.funct3;
   assign is_branch_o = (fld.opcode == OPC_BRANCH);
   assign is_jalr_o   = (fld.opcode == OPC_JALR);
   assign is_jump_o   = (fld.opcode == OPC_JAL) || is_jalr_o;

   always_comb begin
      fn_o = FN_NONE;
      unique case (fld.opcode)
         OPC_REG, OPC_IMM: begin
            unique case (fld.funct3)
               3'b000:  fn_o = (fld.opcode == OPC_REG && fld.alt) ? FN_SUB : FN_ADD;
               3'b001:  fn_o = FN_SLL;
               3'b010:  fn_o = FN_SLT;
               3'b011:  fn_o = FN_SLTU;
               3'b100:  fn_o = FN_XOR;
               3'b101:  fn_o = fld.alt ? FN_SRA : FN_SRL;
               3'b110:  fn_o = FN_OR;
               default: fn_o = FN_AND;
            endcase
         end
         OPC_BRANCH, OPC_JAL, OPC_JALR, OPC_LOAD,
         OPC_STORE, OPC_LUI, OPC_AUIPC: fn_o = FN_ADD;
         default: fn_o = FN_NONE;
      endcase
   end

endmodule

// File: rtl/rvx_exec_shifter.sv
module rvx_exec_shifter #(
   parameter int XLEN    = 32,
   parameter bit STAGED  = 1'b1,
   localparam int SHW    = $clog2(XLEN)
) (
   input  logic [XLEN-1:0] data_i,
   input  logic [SHW-1:0]  amt_i,
   input  logic            left_i,
   input  logic            arith_i,
   output logic [XLEN-1:0] data_o
);

   if (STAGED) begin : g_staged
      logic [XLEN-1:0] rev_in;
      logic [XLEN-1:0] rev_out;
      logic [XLEN-1:0] stage [0:SHW];
      logic            fill;

      always_comb begin
         for (int i = 0; i < XLEN; i++) rev_in[i] = data_i[XLEN-1-i];
      end

      assign fill     = arith_i & ~left_i & data_i[XLEN-1];
      assign stage[0] = left_i ? rev_in : data_i;

      for (genvar k = 0; k < SHW; k++) begin : g_stage
         localparam int DIST = 1 << k;
         assign stage[k+1] = amt_i[k] ? {{DIST{fill}}, stage[k][XLEN-1:DIST]}
                                      : stage[k];
      end

      always_comb begin
         for (int i = 0; i < XLEN; i++) rev_out[i] = stage[SHW][XLEN-1-i];
      end

      assign data_o = left_i ? rev_out : stage[SHW];
   end else begin : g_barrel
      always_comb begin
         if (left_i)       data_o = data_i << amt_i;
         else if (arith_i) data_o = $signed(data_i) >>> amt_i;
         else              data_o = data_i >> amt_i;
      end
   end

endmodule

// File: rtl/rvx_exec_alu.sv
module rvx_exec_alu
   import rvx_exec_pkg::*;
#(
   parameter int XLEN         = 32,
   parameter bit SHIFT_STAGED = 1'b1,
   localparam int SHW         = $clog2(XLEN)
) (
   input  alu_fn_e         fn_i,
   input  logic [XLEN-1:0] a_i,
   input  logic [XLEN-1:0] b_i,
   output logic [XLEN-1:0] y_o
);

   logic [XLEN-1:0] sum;
   logic [XLEN-1:0] diff;
   logic [XLEN-1:0] shifted;
   logic            lt_s;
   logic            lt_u;

   assign sum  = a_i + b_i;
   assign diff = a_i - b_i;
   assign lt_s = $signed(a_i) < $signed(b_i);
   assign lt_u = a_i < b_i;

   rvx_exec_shifter #(
      .XLEN   (XLEN),
      .STAGED (SHIFT_STAGED)
   ) u_shift (
      .data_i  (a_i),
      .amt_i   (b_i[SHW-1:0]),
      .left_i  (fn_i == FN_SLL),
      .arith_i (fn_i == FN_SRA),
      .data_o  (shifted)
   );

   always_comb begin
      unique case (fn_i)
         FN_ADD:                  y_o = sum;
         FN_SUB:                  y_o = diff;
         FN_SLL, FN_SRL, FN_SRA:  y_o = shifted;
         FN_SLT:                  y_o = {{(XLEN-1){1'b0}}, lt_s};
         FN_SLTU:                 y_o = {{(XLEN-1){1'b0}}, lt_u};
         FN_XOR:                  y_o = a_i ^ b_i;
         FN_OR:                   y_o = a_i | b_i;
         FN_AND:                  y_o = a_i & b_i;
         default:                 y_o = '0;
      endcase
   end

endmodule

// File: rtl/rvx_exec_branch.sv
module rvx_exec_branch
   import rvx_exec_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter bit CMP_SHARED = 1'b1
) (
   input  logic [2:0]      funct3_i,
   input  logic            is_branch_i,
   input  logic            is_jump_i,
   input  logic [XLEN-1:0] lhs_i,
   input  logic [XLEN-1:0] rhs_i,
   output logic            take_o
);

   logic equal;
   logic less;
   logic cond;

   assign equal = (lhs_i == rhs_i);

   if (CMP_SHARED) begin : g_shared
      logic          ext_l;
      logic          ext_r;
      logic [XLEN:0] delta;
      assign ext_l = ~funct3_i[1] & lhs_i[XLEN-1];
      assign ext_r = ~funct3_i[1] & rhs_i[XLEN-1];
      assign delta = {ext_l, lhs_i} - {ext_r, rhs_i};
      assign less  = delta[XLEN];
   end else begin : g_direct
      assign less = funct3_i[1] ? (lhs_i < rhs_i)
                                : ($signed(lhs_i) < $signed(rhs_i));
   end

   always_comb begin
      unique case (funct3_i)
         CMP_EQ:           cond = equal;
         CMP_NE:           cond = ~equal;
         CMP_LT, CMP_LTU:  cond = less;
         CMP_GE, CMP_GEU:  cond = ~less;
         default:          cond = 1'b0;
      endcase
   end

   assign take_o = is_jump_i | (is_branch_i & cond);

endmodule

// File: rtl/rvx_exec_unit.sv
module rvx_exec_unit
   import rvx_exec_pkg::*;
#(
   parameter int XLEN         = 32,
   parameter bit SHIFT_STAGED = 1'b1,
   parameter bit CMP_SHARED   = 1'b1
) (
   input  logic [31:0]     instr_i,
   input  logic [XLEN-1:0] pc_i,
   input  logic [XLEN-1:0] rs1_val_i,
   input  logic [XLEN-1:0] rs2_val_i,
   input  logic [XLEN-1:0] imm_i,
   input  logic            op1_pc_sel_i,
   input  logic            op2_imm_sel_i,
   output logic [XLEN-1:0] alu_result_o,
   output logic            jump_taken_o,
   output logic [XLEN-1:0] jump_target_o
);

   if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
      $error("rvx_exec_unit: XLEN must be 32 or 64");
   end

   alu_fn_e         fn;
   logic [2:0]      funct3;
   logic            is_branch;
   logic            is_jump;
   logic            is_jalr;
   logic [XLEN-1:0] op_a;
   logic [XLEN-1:0] op_b;
   logic [XLEN-1:0] alu_y;

   rvx_exec_fn_decode u_dec (
      .instr_i     (instr_i),
      .fn_o        (fn),
      .funct3_o    (funct3),
      .is_branch_o (is_branch),
      .is_jump_o   (is_jump),
      .is_jalr_o   (is_jalr)
   );

   assign op_a = op1_pc_sel_i  ? pc_i  : rs1_val_i;
   assign op_b = op2_imm_sel_i ? imm_i : rs2_val_i;

   rvx_exec_alu #(
      .XLEN         (XLEN),
      .SHIFT_STAGED (SHIFT_STAGED)
   ) u_alu (
      .fn_i (fn),
      .a_i  (op_a),
      .b_i  (op_b),
      .y_o  (alu_y)
   );

   rvx_exec_branch #(
      .XLEN       (XLEN),
      .CMP_SHARED (CMP_SHARED)
   ) u_br (
      .funct3_i    (funct3),
      .is_branch_i (is_branch),
      .is_jump_i   (is_jump),
      .lhs_i       (rs1_val_i),
      .rhs_i       (rs2_val_i),
      .take_o      (jump_taken_o)
   );

   assign alu_result_o  = alu_y;
   assign jump_target_o = {alu_y[XLEN-1:1], alu_y[0] & ~is_jalr};

endmodule

// File: rtl/rvx_exec_unit_chk.sv
module rvx_exec_unit_chk #(
   parameter int XLEN = 32
) (
   input logic [31:0]     instr_i,
   input logic [XLEN-1:0] pc_i,
   input logic [XLEN-1:0] rs1_val_i,
   input logic [XLEN-1:0] rs2_val_i,
   input logic [XLEN-1:0] imm_i,
   input logic            op1_pc_sel_i,
   input logic            op2_imm_sel_i,
   input logic [XLEN-1:0] alu_result_o,
   input logic            jump_taken_o,
   input logic [XLEN-1:0] jump_target_o
);

   logic [6:0] opc;
   logic [2:0] f3;
   logic       known;
   logic       ctl;
   logic       unused_chk;

   assign opc        = instr_i[6:0];
   assign f3         = instr_i[14:12];
   assign unused_chk = ^{instr_i[31:15], instr_i[11:7]};
   assign ctl        = (opc == 7'b1100011) || (opc == 7'b1101111) || (opc == 7'b1100111);
   assign known      = ctl || (opc == 7'b0110011) || (opc == 7'b0010011) ||
                       (opc == 7'b0000011) || (opc == 7'b0100011) ||
                       (opc == 7'b0110111) || (opc == 7'b0010111);

   always_comb begin
      if (!$isunknown({instr_i, pc_i, rs1_val_i, rs2_val_i, imm_i,
                       op1_pc_sel_i, op2_imm_sel_i})) begin
         if (opc == 7'b1101111)
            assert_jal_taken_R9: assert (jump_taken_o);
         if (opc == 7'b1100111)
            assert_jalr_even_R10: assert (jump_taken_o && !jump_target_o[0]);
         if (!ctl)
            assert_no_jump_R11: assert (!jump_taken_o);
         if (opc == 7'b1100011 || opc == 7'b1101111)
            assert_target_sum_R6: assert (jump_target_o == alu_result_o);
         if (opc == 7'b1100011 && f3 == 3'b000)
            assert_beq_regs_R7: assert (jump_taken_o == (rs1_val_i == rs2_val_i));
         if (!known)
            assert_unknown_zero_R12: assert (alu_result_o == '0 && !jump_taken_o);
         if (opc == 7'b0000011 && !op1_pc_sel_i && !op2_imm_sel_i)
            assert_op_regs_R1: assert (alu_result_o - rs2_val_i == rs1_val_i);
         if (opc == 7'b0000011 && op1_pc_sel_i && op2_imm_sel_i)
            assert_op_pcimm_R2: assert (alu_result_o - imm_i == pc_i);
      end
   end

endmodule

bind rvx_exec_unit rvx_exec_unit_chk #(.XLEN(XLEN)) u_chk (
   .instr_i       (instr_i),
   .pc_i          (pc_i),
   .rs1_val_i     (rs1_val_i),
   .rs2_val_i     (rs2_val_i),
   .imm_i         (imm_i),
   .op1_pc_sel_i  (op1_pc_sel_i),
   .op2_imm_sel_i (op2_imm_sel_i),
   .alu_result_o  (alu_result_o),
   .jump_taken_o  (jump_taken_o),
   .jump_target_o (jump_target_o)
);

// File: tb/rvx_exec_unit_bench.sv
module rvx_exec_unit_bench;

   logic        clk = 1'b0;
   logic [31:0] instr;
   logic [31:0] pc;
   logic [31:0] rs1;
   logic [31:0] rs2;
   logic [31:0] imm;
   logic        sel1;
   logic        sel2;
   logic [31:0] res;
   logic        jt;
   logic [31:0] tgt;

   int checks   = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   rvx_exec_unit u_rvx_exec_unit (
      .instr_i       (instr),
      .pc_i          (pc),
      .rs1_val_i     (rs1),
      .rs2_val_i     (rs2),
      .imm_i         (imm),
      .op1_pc_sel_i  (sel1),
      .op2_imm_sel_i (sel2),
      .alu_result_o  (res),
      .jump_taken_o  (jt),
      .jump_target_o (tgt)
   );

   function automatic logic [31:0] val(input int i);
      case (i)
         0:  return 32'h0000_0000;  1:  return 32'h0000_0001;
         2:  return 32'h0000_0002;  3:  return 32'h7FFF_FFFF;
         4:  return 32'h8000_0000;  5:  return 32'hFFFF_FFFF;
         6:  return 32'h0000_001F;  7:  return 32'h0000_0020;
         8:  return 32'h0000_0021;  9:  return 32'hDEAD_BEEF;
         10: return 32'h1234_5678;  11: return 32'h0000_FFFF;
         12: return 32'h8000_0001;  13: return 32'h5500_7700;
         14: return 32'h90A1_B2C3;  default: return 32'hFFFF_FFFE;
      endcase
   endfunction

   function automatic logic [31:0] mk(input logic [6:0] op, input logic [2:0] f3,
                                      input logic alt);
      return {1'b0, alt, 5'd0, 5'd3, 5'd2, f3, 5'd1, op};
   endfunction

   function automatic logic [31:0] exp_alu(input logic reg_form, input logic [2:0] f3,
                                           input logic alt, input logic [31:0] a,
                                           input logic [31:0] b);
      case (f3)
         3'd0: return (reg_form && alt) ? a - b : a + b;
         3'd1: return a << b[4:0];
         3'd2: return {31'd0, $signed(a) < $signed(b)};
         3'd3: return {31'd0, a < b};
         3'd4: return a ^ b;
         3'd5: return alt ? 32'($signed(a) >>> b[4:0]) : a >> b[4:0];
         3'd6: return a | b;
         default: return a & b;
      endcase
   endfunction

   function automatic logic exp_take(input logic [2:0] f3, input logic [31:0] a,
                                     input logic [31:0] b);
      case (f3)
         3'd0: return a == b;
         3'd1: return a != b;
         3'd4: return $signed(a) < $signed(b);
         3'd5: return $signed(a) >= $signed(b);
         3'd6: return a < b;
         3'd7: return a >= b;
         default: return 1'b0;
      endcase
   endfunction

   function automatic string alu_tag(input logic [2:0] f3);
      case (f3)
         3'd1, 3'd5: return "R4";
         3'd2, 3'd3: return "R5";
         default:    return "R3";
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s instr=%h got=%h exp=%h", req, instr, got, exp);
      end
   endtask

   task automatic drive(input logic [31:0] i, input logic [31:0] p, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] im,
                        input logic s1, input logic s2);
      @(negedge clk);
      instr = i; pc = p; rs1 = a; rs2 = b; imm = im; sel1 = s1; sel2 = s2;
      #1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      instr = '0; pc = '0; rs1 = '0; rs2 = '0; imm = '0; sel1 = 1'b0; sel2 = 1'b0;
      repeat (3) @(posedge clk);

      // idle word (opcode 0000000): R12
      drive(32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0);
      chk("R12 idle result", res, 32'h0);
      chk("R12 idle flag", {31'd0, jt}, 32'h0);

      // register-register and register-immediate sweep: R3 R4 R5 R11
      for (int form = 0; form < 2; form++) begin
         for (int f3 = 0; f3 < 8; f3++) begin
            for (int alt = 0; alt < 2; alt++) begin
               for (int i = 0; i < 16; i++) begin
                  for (int j = 0; j < 16; j++) begin
                     logic [31:0] a;
                     logic [31:0] b;
                     a = val(i);
                     b = val(j) ^ 32'(j * 32'h0101_0000);
                     if (form == 0) begin
                        drive(mk(7'b0110011, 3'(f3), alt[0]), 32'h1000, a, b,
                              32'hCAFE_0000, 1'b0, 1'b0);
                        chk(alu_tag(3'(f3)), res, exp_alu(1'b1, 3'(f3), alt[0], a, b));
                     end else begin
                        drive(mk(7'b0010011, 3'(f3), alt[0]), 32'h1000, a, 32'h0BAD_0000,
                              b, 1'b0, 1'b1);
                        chk(alu_tag(3'(f3)), res, exp_alu(1'b0, 3'(f3), alt[0], a, b));
                     end
                     chk("R11 arith flag", {31'd0, jt}, 32'h0);
                  end
               end
            end
         end
      end

      // operand select combinations on a load: R1 R2
      for (int s = 0; s < 4; s++) begin
         drive(mk(7'b0000011, 3'd2, 1'b0), 32'h0000_4000, 32'h0000_0300,
               32'h0000_0020, 32'h0000_0005, s[0], s[1]);
         chk(s[0] ? "R1 op1=pc" : "R1 op1=rs1", res,
             (s[0] ? 32'h4000 : 32'h300) + (s[1] ? 32'h5 : 32'h20));
         chk(s[1] ? "R2 op2=imm" : "R2 op2=rs2", res,
             (s[0] ? 32'h4000 : 32'h300) + (s[1] ? 32'h5 : 32'h20));
      end

      // branches: comparator and target adder together, R6 R7 R8 R11
      for (int f3 = 0; f3 < 8; f3++) begin
         for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
               logic [31:0] p;
               logic [31:0] im;
               p  = 32'h0000_101C + 32'(i * 64);
               im = 32'(j * 8) - 32'h40;
               drive(mk(7'b1100011, 3'(f3), 1'b0), p, val(i), val(j), im, 1'b1, 1'b1);
               chk((f3 == 2 || f3 == 3) ? "R11 bad branch" :
                   (f3 < 2) ? "R7 eq/ne flag" : "R8 ordered flag",
                   {31'd0, jt}, {31'd0, exp_take(3'(f3), val(i), val(j))});
               chk("R6 branch target", tgt, p + im);
               chk("R6 branch result", res, p + im);
            end
         end
      end

      // jal: R9
      for (int k = 0; k < 8; k++) begin
         logic [31:0] p;
         p = 32'h0000_101C + 32'(k * 4);
         drive(mk(7'b1101111, 3'(k), 1'b0), p, val(k), val(k + 1), 32'h84, 1'b1, 1'b1);
         chk("R9 jal flag", {31'd0, jt}, 32'h1);
         chk("R9 jal target", tgt, p + 32'h84);
      end

      // jalr with odd and even sums: R10
      for (int k = 0; k < 8; k++) begin
         logic [31:0] base;
         base = 32'h0000_2000 + 32'(k);
         drive(mk(7'b1100111, 3'd0, 1'b0), 32'h0000_0800, base, 32'h0, 32'h11, 1'b0, 1'b1);
         chk("R10 jalr flag", {31'd0, jt}, 32'h1);
         chk("R10 jalr target", tgt, (base + 32'h11) & ~32'h1);
         chk("R10 jalr result", res, base + 32'h11);
      end

      // store, lui, auipc: add, no jump, R6 R11
      drive(mk(7'b0100011, 3'd2, 1'b0), 32'h0000_1020, 32'h0000_0000, 32'h0000_1020,
            32'hFFFF_FFF8, 1'b0, 1'b1);
      chk("R6 store address", res, 32'hFFFF_FFF8);
      chk("R11 store flag", {31'd0, jt}, 32'h0);
      drive(mk(7'b0110111, 3'd0, 1'b0), 32'h0000_1020, 32'h0, 32'h0, 32'h1234_5000,
            1'b0, 1'b1);
      chk("R6 lui result", res, 32'h1234_5000);
      chk("R11 lui flag", {31'd0, jt}, 32'h0);
      drive(mk(7'b0010111, 3'd0, 1'b0), 32'h0000_1020, 32'h0, 32'h0, 32'h0000_3000,
            1'b1, 1'b1);
      chk("R6 auipc result", res, 32'h0000_4020);
      chk("R11 auipc flag", {31'd0, jt}, 32'h0);

      // unsupported opcodes: R12
      for (int k = 0; k < 4; k++) begin
         logic [6:0] op;
         op = (k == 0) ? 7'b1111111 : (k == 1) ? 7'b0001111 :
              (k == 2) ? 7'b1110011 : 7'b0101111;
         drive(mk(op, 3'd0, 1'b0), 32'h0000_1000, 32'h5555_0000, 32'h0000_AAAA,
               32'h0000_0004, 1'b1, 1'b1);
         chk("R12 unknown result", res, 32'h0);
         chk("R12 unknown flag", {31'd0, jt}, 32'h0);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule